// File: doc/BRIEF.md
# Four-bank host register interface with sticky per-bank interrupts

This block lets a simple asynchronous host bus reach four identical banks of byte-wide registers. The host drives an active-low select, separate active-low read and write strobes, a two-bit bank number and a four-bit register address. The block samples the strobes in its own clock domain. Write data is committed when the write strobe returns high. Read data is driven out combinationally, together with an output-enable that an external pad ring uses to drive the shared bidirectional byte lane.

Each bank also keeps a four-bit status word. The word is fed by single-cycle event pulses from that bank's transmit and receive logic. Any set status bit raises the bank's interrupt line. The line stays high until the host finishes reading that bank's status register. Only the bits the host was shown are then cleared, so no event is lost.

Top module: `mpr_host_if`

## Requirements
- R1: With `csN` high, a write strobe changes no register, and `dataOe` stays 0 while `rdN` is low.
- R2: A write with `csN` low stores `dataIn` into the addressed register on the rising edge of `wrN`. The new value reads back no later than four clock cycles after that edge.
- R3: `portSel` values 0, 1, 2 and 3 select banks 1 to 4. A write to one bank leaves the other banks unchanged.
- R4: Addresses 1 to 7, with `addr[3]` = 0, are read/write byte registers. Any address with `addr[3]` = 1 reads as 0 and ignores writes, so an undriven top bit pulled to 0 reaches the registers.
- R5: `dataOe` is 1 only while both `csN` and `rdN` are low. `dataOut` is 0 whenever `dataOe` is 0.
- R6: Address 0 is the bank's status register. Bits [3:0] are transmit done, transmit error, receive ready and receive error, taken from `portEvt[4p+3:4p]` in that order. Bits [7:4] read 0. A pulse on any event bit sets that status bit and raises `irq[p]` on the next clock.
- R7: `irq[p]` stays high until a status read of bank p completes. Reading any other register does not lower it.
- R8: The clear takes effect only after `rdN` returns high. It clears only the bits that were set when the read began. An event that arrives during the read, or in the clear cycle itself, stays set.
- R9: A write to address 0 has no effect.
- R10: While `rstN` is low, all registers, status bits and interrupts are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low reset |
| csN | input | 1 | Active-low register access select |
| rdN | input | 1 | Active-low read strobe |
| wrN | input | 1 | Active-low write strobe |
| portSel | input | 2 | Bank number, bit 1 is the MSB |
| addr | input | 4 | Register address within the bank |
| dataIn | input | 8 | Write data from the byte lane |
| dataOut | output | 8 | Read data toward the byte lane |
| dataOe | output | 1 | Drive enable for the byte lane |
| portEvt | input | 16 | Event pulses, four per bank |
| irq | output | 4 | Per-bank interrupt, active high |

## Verification
The hardest case to reach is an event pulse that lands in the same clock as the status clear. Only one cycle in the synchronizer pipeline after `rdN` rises is open for it. The stimulus raises `rdN` on a falling clock edge and applies the event two falling edges later. That puts the pulse on the same rising edge that applies the clear. The expected status is then only the new bit, with the interrupt still high. A similar sequence injects an event while the strobe is held low, which shows that the read snapshot, not the live word, sets the clear mask.

// File: rtl/mpr_pkg.sv
package mpr_pkg;
  localparam int NPORTS = 4;
  localparam int PORT_W = 2;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 4;
  localparam int REG_W  = 3;
  localparam int EVT_W  = 4;
  localparam int NREG   = 1 << REG_W;

  typedef struct packed {
    logic              wrStb;
    logic [PORT_W-1:0] wrPort;
    logic [ADDR_W-1:0] wrAddr;
    logic [DATA_W-1:0] wrData;
    logic              rdSnap;
    logic [PORT_W-1:0] rdPort;
    logic              rdClr;
    logic [PORT_W-1:0] clrPort;
  } hostCmd_t;
endpackage

// File: rtl/mpr_ctrl.sv
module mpr_ctrl
  import mpr_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              csN,
  input  logic              rdN,
  input  logic              wrN,
  input  logic [PORT_W-1:0] portSel,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] dataIn,
  output hostCmd_t          cmd
);
  logic [1:0] csSync, rdSync, wrSync;
  logic csS, rdS, wrS, rdPrev, wrPrev;
  logic [PORT_W-1:0] portS1, portS2, wrHeldPort, rdArmPort;
  logic [ADDR_W-1:0] addrS1, addrS2, wrHeldAddr;
  logic [DATA_W-1:0] dataS1, dataS2, wrHeldData;
  logic wrHeldCs, rdArm;
  logic wrRise, rdFall, rdRise, rdSnap;

  assign csS = csSync[1];
  assign rdS = rdSync[1];
  assign wrS = wrSync[1];

  // Two-stage synchronizers for strobes; bus fields ride alongside
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      csSync <= '1; rdSync <= '1; wrSync <= '1;
      rdPrev <= 1'b1; wrPrev <= 1'b1;
      portS1 <= '0; portS2 <= '0;
      addrS1 <= '0; addrS2 <= '0;
      dataS1 <= '0; dataS2 <= '0;
    end else begin
      csSync <= {csSync[0], csN};
      rdSync <= {rdSync[0], rdN};
      wrSync <= {wrSync[0], wrN};
      rdPrev <= rdS;
      wrPrev <= wrS;
      portS1 <= portSel; portS2 <= portS1;
      addrS1 <= addr;    addrS2 <= addrS1;
      dataS1 <= dataIn;  dataS2 <= dataS1;
    end
  end

  // Last sample taken while the write strobe was low is what gets committed
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrHeldCs <= 1'b0; wrHeldPort <= '0; wrHeldAddr <= '0; wrHeldData <= '0;
    end else if (!wrS) begin
      wrHeldCs <= !csS; wrHeldPort <= portS2; wrHeldAddr <= addrS2; wrHeldData <= dataS2;
    end
  end

  assign wrRise = wrS && !wrPrev;
  assign rdFall = !rdS && rdPrev;
  assign rdRise = rdS && !rdPrev;
  assign rdSnap = rdFall && !csS && (addrS2 == '0);

  // A status read arms at strobe fall and fires the clear at strobe rise
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdArm <= 1'b0; rdArmPort <= '0;
    end else if (rdSnap) begin
      rdArm <= 1'b1; rdArmPort <= portS2;
    end else if (rdRise) begin
      rdArm <= 1'b0;
    end
  end

  always_comb begin
    cmd.wrStb   = wrRise && wrHeldCs;
    cmd.wrPort  = wrHeldPort;
    cmd.wrAddr  = wrHeldAddr;
    cmd.wrData  = wrHeldData;
    cmd.rdSnap  = rdSnap;
    cmd.rdPort  = portS2;
    cmd.rdClr   = rdRise && rdArm;
    cmd.clrPort = rdArmPort;
  end

  AST_WR_CS_QUAL: assert property (@(posedge clk) disable iff (!rstN)
    cmd.wrStb |-> !$past(csS)); // R1
  AST_WR_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    cmd.wrStb |=> !cmd.wrStb); // R2
  AST_CLR_AFTER_SNAP: assert property (@(posedge clk) disable iff (!rstN)
    cmd.rdSnap |=> !cmd.rdClr); // R8
endmodule

// File: rtl/mpr_regs.sv
module mpr_regs
  import mpr_pkg::*;
(
  input  logic                    clk,
  input  logic                    rstN,
  input  hostCmd_t                cmd,
  input  logic [NPORTS*EVT_W-1:0] portEvt,
  input  logic [PORT_W-1:0]       rdPortSel,
  input  logic [ADDR_W-1:0]       rdAddr,
  output logic [DATA_W-1:0]       rdData,
  output logic [NPORTS-1:0]       irq
);
  logic [NPORTS-1:0][NREG-2:0][DATA_W-1:0] bank;
  logic [NPORTS-1:0][EVT_W-1:0] stat;
  logic [EVT_W-1:0] snap;
  logic [REG_W-1:0] wrLow, rdLow;
  logic wrMapped, rdMapped;

  assign wrLow    = cmd.wrAddr[REG_W-1:0];
  assign rdLow    = rdAddr[REG_W-1:0];
  assign wrMapped = (cmd.wrAddr[ADDR_W-1:REG_W] == '0) && (wrLow != '0);
  assign rdMapped = (rdAddr[ADDR_W-1:REG_W] == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bank <= '0;
    end else if (cmd.wrStb && wrMapped) begin
      bank[cmd.wrPort][wrLow - REG_W'(1)] <= cmd.wrData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) snap <= '0;
    else if (cmd.rdSnap) snap <= stat[cmd.rdPort];
  end

  generate
    for (genvar p = 0; p < NPORTS; p++) begin : g_port
      logic [EVT_W-1:0] evtP, clrMask;
      assign evtP    = portEvt[p*EVT_W +: EVT_W];
      assign clrMask = (cmd.rdClr && cmd.clrPort == PORT_W'(p)) ? snap : '0;

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) stat[p] <= '0;
        else       stat[p] <= (stat[p] & ~clrMask) | evtP;
      end

      assign irq[p] = |stat[p];

      AST_EVT_LATCH: assert property (@(posedge clk) disable iff (!rstN)
        (|evtP) |=> ((stat[p] & $past(evtP)) == $past(evtP))); // R6
      AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rstN)
        (irq[p] && !(cmd.rdClr && cmd.clrPort == PORT_W'(p))) |=> irq[p]); // R7
    end
  endgenerate

  always_comb begin
    rdData = '0;
    if (rdMapped) begin
      if (rdLow == '0) rdData = DATA_W'(stat[rdPortSel]);
      else             rdData = bank[rdPortSel][rdLow - REG_W'(1)];
    end
  end

  AST_BANK_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !cmd.wrStb |=> $stable(bank)); // R2
  AST_STATUS_RO: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.wrStb && cmd.wrAddr == '0) |=> $stable(bank)); // R9
endmodule

// File: rtl/mpr_host_if.sv
module mpr_host_if
  import mpr_pkg::*;
(
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    csN,
  input  logic                    rdN,
  input  logic                    wrN,
  input  logic [PORT_W-1:0]       portSel,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [DATA_W-1:0]       dataIn,
  output logic [DATA_W-1:0]       dataOut,
  output logic                    dataOe,
  input  logic [NPORTS*EVT_W-1:0] portEvt,
  output logic [NPORTS-1:0]       irq
);
  hostCmd_t cmd;
  logic [DATA_W-1:0] rdData;

  mpr_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .csN(csN), .rdN(rdN), .wrN(wrN),
    .portSel(portSel), .addr(addr), .dataIn(dataIn), .cmd(cmd)
  );

  mpr_regs regs_i (
    .clk(clk), .rstN(rstN), .cmd(cmd), .portEvt(portEvt),
    .rdPortSel(portSel), .rdAddr(addr), .rdData(rdData), .irq(irq)
  );

  assign dataOe  = !csN && !rdN;
  assign dataOut = dataOe ? rdData : '0;

  AST_IRQ_RESET: assert property (@(posedge clk) !rstN |=> irq == '0); // R10
endmodule

// File: tb/mpr_host_if_tb_top.sv
`timescale 1ns/1ps
module mpr_host_if_tb_top;
  logic clk = 0, rstN = 0, csN = 1, rdN = 1, wrN = 1;
  logic [1:0] portSel = 0;
  logic [3:0] addr = 0;
  logic [7:0] dataIn = 0, dataOut;
  logic dataOe;
  logic [15:0] portEvt = 0;
  logic [3:0] irq;
  int checks = 0, errors = 0;
  bit done = 0;
  logic [7:0] rdVal;
  logic rdOe;
  logic [7:0] mdl [4][16];

  always #4 clk = ~clk;

  mpr_host_if dut_i (.clk(clk), .rstN(rstN), .csN(csN), .rdN(rdN), .wrN(wrN),
    .portSel(portSel), .addr(addr), .dataIn(dataIn), .dataOut(dataOut),
    .dataOe(dataOe), .portEvt(portEvt), .irq(irq));

  // {bank, address, data}
  localparam logic [13:0] VECS [10] = '{
    {2'd0, 4'd1, 8'h11}, {2'd1, 4'd1, 8'h22}, {2'd2, 4'd1, 8'h33},
    {2'd3, 4'd1, 8'h44}, {2'd0, 4'd7, 8'hA5}, {2'd3, 4'd5, 8'h5A},
    {2'd2, 4'd0, 8'hFF}, {2'd1, 4'd9, 8'hC3}, {2'd1, 4'd3, 8'h77},
    {2'd0, 4'd1, 8'h99}};

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic hostWrite(logic [1:0] p, logic [3:0] a, logic [7:0] d, bit sel);
    @(negedge clk);
    portSel = p; addr = a; dataIn = d; csN = !sel; wrN = 0;
    repeat (4) @(negedge clk);
    wrN = 1;
    repeat (4) @(negedge clk);
    csN = 1;
    repeat (2) @(negedge clk);
  endtask

  task automatic startRead(logic [1:0] p, logic [3:0] a);
    @(negedge clk);
    portSel = p; addr = a; csN = 0; rdN = 0;
    #1; rdVal = dataOut; rdOe = dataOe;
  endtask

  task automatic endRead();
    repeat (4) @(negedge clk);
    rdN = 1;
    repeat (5) @(negedge clk);
    csN = 1;
    @(negedge clk);
  endtask

  task automatic pulseEvt(logic [15:0] e);
    @(negedge clk); portEvt = e;
    @(negedge clk); portEvt = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int p = 0; p < 4; p++) for (int a = 0; a < 16; a++) mdl[p][a] = 0;
    repeat (3) @(negedge clk);
    chk("R10 irq in reset", {4'b0, irq}, 8'h00);
    rstN = 1;
    startRead(0, 1); chk("R10 reg after reset", rdVal, 8'h00); endRead();

    // R2 R3 R4 R9 table walk
    for (int i = 0; i < 10; i++) begin
      hostWrite(VECS[i][13:12], VECS[i][11:8], VECS[i][7:0], 1'b1);
      if (VECS[i][11:8] != 0 && VECS[i][11:8] < 8)
        mdl[VECS[i][13:12]][VECS[i][11:8]] = VECS[i][7:0];
    end
    for (int i = 0; i < 10; i++) begin
      startRead(VECS[i][13:12], VECS[i][11:8]);
      chk("R2/R3/R4/R9 readback", rdVal, mdl[VECS[i][13:12]][VECS[i][11:8]]);
      chk("R5 oe during read", {7'b0, rdOe}, 8'h01);
      endRead();
    end
    startRead(2, 1); chk("R3 other bank intact", rdVal, 8'h33); endRead();

    // R1: write without select
    hostWrite(0, 2, 8'hEE, 1'b0);
    startRead(0, 2); chk("R1 unselected write", rdVal, 8'h00); endRead();
    @(negedge clk); csN = 1; rdN = 0; #1;
    chk("R1 oe without select", {7'b0, dataOe}, 8'h00);
    chk("R5 bus idle", dataOut, 8'h00);
    @(negedge clk); rdN = 1;

    // R6 R7 R8: events on bank 2 (index 1)
    pulseEvt(16'h00A0);
    @(negedge clk);
    chk("R6 irq raised", {4'b0, irq}, 8'h02);
    startRead(1, 3); endRead();
    chk("R7 irq after other read", {4'b0, irq}, 8'h02);
    startRead(1, 0);
    chk("R6 status bits", rdVal, 8'h0A);
    repeat (4) @(negedge clk);
    chk("R8 irq held during read", {4'b0, irq}, 8'h02);
    rdN = 1; repeat (5) @(negedge clk); csN = 1; @(negedge clk);
    chk("R8 irq cleared", {4'b0, irq}, 8'h00);

    // R8: event during read survives
    pulseEvt(16'h0100);
    startRead(2, 0);
    chk("R6 rx-less status", rdVal, 8'h01);
    repeat (4) @(negedge clk);
    portEvt = 16'h0400; @(negedge clk); portEvt = 0;
    rdN = 1; repeat (5) @(negedge clk); csN = 1; @(negedge clk);
    startRead(2, 0); chk("R8 event during read kept", rdVal, 8'h04); endRead();
    chk("R8 irq after read-clear", {4'b0, irq}, 8'h00);

    // R8: event in the clear cycle survives
    pulseEvt(16'h2000);
    startRead(3, 0);
    chk("R6 bank4 status", rdVal, 8'h02);
    repeat (4) @(negedge clk);
    rdN = 1;
    repeat (2) @(negedge clk);
    portEvt = 16'h8000; @(negedge clk); portEvt = 0;
    repeat (3) @(negedge clk); csN = 1; @(negedge clk);
    chk("R8 same-cycle irq", {4'b0, irq}, 8'h08);
    startRead(3, 0); chk("R8 same-cycle event kept", rdVal, 8'h08); endRead();

    // R10: reset clears everything
    pulseEvt(16'h0010);
    @(negedge clk); rstN = 0;
    @(negedge clk);
    chk("R10 irq cleared by reset", {4'b0, irq}, 8'h00);
    rstN = 1;
    startRead(0, 7); chk("R10 reg cleared", rdVal, 8'h00); endRead();
    startRead(1, 0); chk("R10 status cleared", rdVal, 8'h00); endRead();

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule